// File: doc/BRIEF.md
# Serial EEPROM Transaction Controller

This block drives a two-wire serial bus on behalf of a host that wants to store or fetch bytes in a small EEPROM. The host presents one command: an operation, a 3-bit device select, an 8-bit word address and a byte count. The controller then produces the whole bus transaction: the start conditions, the header bytes, the address, the data phase and the closing stop. Write data is pulled from the host one byte at a time. Each received byte is handed back with a single-cycle strobe.

Both lines are open drain. The block only ever pulls a line low or lets it go. The clock line is built from the system clock by a quarter-bit divider, so one bit always takes four quarters. The block sees a missing acknowledge from the target, cuts the transaction short with a stop, and flags the failure. A command that cannot be carried out is refused before any bus activity.

Operation codes: 0 writes `cmd_len` bytes starting at `cmd_addr` (a length of 1 is a single-byte write, up to `PAGE_MAX` is a page write). 1 reads `cmd_len` bytes starting at `cmd_addr`, through a dummy write and a repeated start. 2 reads `cmd_len` bytes from wherever the target's internal pointer stands. 3 is reserved.

Top module: `eeprom_i2c_ctrl`

## Requirements
- R1: After reset, `cmd_ready` is 1, `done` and `err` are 0, and neither `scl_oe` nor `sda_oe` pulls its line low; the lines stay released whenever the controller is idle.
- R2: Every transaction opens with a start condition followed by a header byte whose bits, MSB first, are 1,0,1,0, then `cmd_dev[2:0]`, then the direction bit (0 = write, 1 = read).
- R3: Operation 0 sends the write header, the word address and then exactly `cmd_len` data bytes. Each data byte is taken from `wr_data` in the cycle before a one-cycle `wr_take` pulse. A single stop follows the last byte.
- R4: Operation 1 sends the write header and the word address, then a repeated start, then the read header, then receives `cmd_len` bytes. The whole transaction has exactly two start conditions and one stop.
- R5: Operation 2 sends only a start and the read header before receiving data. No word address is put on the bus.
- R6: While receiving, the controller acknowledges (drives SDA low in the ninth bit) every byte except the last. It leaves the last byte unacknowledged, then issues the stop.
- R7: If SDA is high in any acknowledge slot the controller expects the target to drive, no further byte is sent. The controller issues a stop, raises `err` and pulses `done`. `err` holds until the next accepted command.
- R8: A command with operation 3, with `cmd_len` of 0, or a write with `cmd_len` above `PAGE_MAX` (8) is refused. `err` is set and `done` pulses in the cycle after acceptance, and the bus never leaves idle.
- R9: The controller changes SDA only while SCL is low, except for the start and stop conditions themselves. As a result, each transaction shows exactly the start and stop conditions its operation calls for.
- R10: Bytes travel MSB first in both directions. Each received byte appears on `rd_data` with a `rd_valid` pulse exactly one cycle wide.
- R11: `done` is a one-cycle pulse at the end of every command. `cmd_ready` is 0 from the cycle after a valid command is accepted until the transaction ends.
- R12: During a transaction, consecutive rising edges of SCL are exactly 4 x `QTR_CYC` system clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present; taken when `cmd_ready` is 1 |
| cmd_ready | output | 1 | Controller idle and able to take a command |
| cmd_op | input | 2 | Operation: 0 write, 1 addressed read, 2 read at current pointer, 3 reserved |
| cmd_dev | input | 3 | Device select bits placed in the header |
| cmd_addr | input | 8 | Word address inside the EEPROM |
| cmd_len | input | LEN_W | Number of data bytes to move |
| wr_data | input | 8 | Next byte to write; held until `wr_take` |
| wr_take | output | 1 | One-cycle pulse: `wr_data` has been loaded |
| rd_data | output | 8 | Last byte received |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds a new byte |
| done | output | 1 | One-cycle pulse at command completion |
| err | output | 1 | Last command failed (refused or not acknowledged) |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| sda_i | input | 1 | Resolved level of the data line |

## Verification
A bad step or symbol register shows up quickly at the ports. It sends the wrong number of bytes or leaves out or adds a repeated start, so the target model's start/stop count and the data written or returned stop matching within the same transaction. A bit counter or shift register that is off by one turns every byte into a shifted value, and this reaches the target memory or `rd_data` on the first byte. An error in the acknowledge handling appears either as a wrong `err` at the `done` pulse or as a wrong ACK/NACK count seen on the bus. A wrong divider or quarter counter breaks the fixed rise-to-rise spacing of SCL from the first bit onward.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_RREAD = 2'd1,
        OP_CREAD = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_TX,
        S_RX,
        S_STOP
    } sym_e;

    typedef enum logic [2:0] {
        P_HDRW,
        P_ADDR,
        P_WDATA,
        P_HDRR,
        P_RDATA
    } step_e;

    localparam logic [3:0] HDR_FIXED = 4'b1010;

endpackage

// File: rtl/eeprom_i2c_qtick.sv
module eeprom_i2c_qtick #(
    parameter int QTR_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = '0;
            tick  = 1'b1;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/eeprom_i2c_cmdchk.sv
module eeprom_i2c_cmdchk
    import eeprom_i2c_pkg::*;
#(
    parameter int LEN_W    = 4,
    parameter int PAGE_MAX = 8
) (
    input  logic [1:0]       op,
    input  logic [LEN_W-1:0] len,
    output logic             ok
);
    localparam logic [LEN_W-1:0] PMAX = LEN_W'(PAGE_MAX);

    always_comb begin
        ok = 1'b1;
        if (op == OP_RSVD)                  ok = 1'b0;
        if (len == '0)                      ok = 1'b0;
        if (op == OP_WRITE && len > PMAX)   ok = 1'b0;
    end

endmodule

// File: rtl/eeprom_i2c_seq.sv
module eeprom_i2c_seq
    import eeprom_i2c_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cmd_fire,
    input  logic             cmd_ok,
    input  logic [1:0]       cmd_op,
    input  logic [2:0]       cmd_dev,
    input  logic [7:0]       cmd_addr,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [7:0]       wr_data,
    input  logic             sda_i,
    output logic             busy,
    output logic             wr_take,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             done,
    output logic             err,
    output logic             scl_low,
    output logic             sda_low
);
    localparam logic [LEN_W-1:0] ONE = LEN_W'(1);
    localparam logic [3:0]       ACK_BIT = 4'd8;

    typedef struct packed {
        sym_e             sym;
        step_e            step;
        logic [1:0]       q;
        logic [3:0]       bitn;
        logic [7:0]       sh;
        logic [LEN_W-1:0] left;
        logic [1:0]       op;
        logic [2:0]       dev;
        logic [7:0]       addr;
        logic             fail;
        logic             scl_low;
        logic             sda_low;
        logic             err;
        logic             done;
        logic             rd_valid;
        logic [7:0]       rd_data;
        logic             wr_take;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.done     = 1'b0;
        s_d.rd_valid = 1'b0;
        s_d.wr_take  = 1'b0;
        if (s_q.sym == S_IDLE) begin
            s_d.scl_low = 1'b0;
            s_d.sda_low = 1'b0;
            if (cmd_fire) begin
                if (!cmd_ok) begin
                    s_d.err  = 1'b1;
                    s_d.done = 1'b1;
                end else begin
                    s_d.err  = 1'b0;
                    s_d.fail = 1'b0;
                    s_d.op   = cmd_op;
                    s_d.dev  = cmd_dev;
                    s_d.addr = cmd_addr;
                    s_d.left = cmd_len;
                    s_d.q    = 2'd0;
                    s_d.sym  = S_START;
                    s_d.step = (cmd_op == OP_CREAD) ? P_HDRR : P_HDRW;
                end
            end
        end else if (tick) begin
            s_d.q = s_q.q + 2'd1;
            case (s_q.sym)
                S_START: begin
                    case (s_q.q)
                        2'd0: begin s_d.scl_low = 1'b1; s_d.sda_low = 1'b0; end
                        2'd1: s_d.scl_low = 1'b0;
                        2'd2: s_d.sda_low = 1'b1;
                        default: begin
                            s_d.scl_low = 1'b1;
                            s_d.sym     = S_TX;
                            s_d.bitn    = 4'd0;
                            s_d.sh      = {HDR_FIXED, s_q.dev, s_q.step == P_HDRR};
                        end
                    endcase
                end
                S_TX: begin
                    case (s_q.q)
                        2'd0: begin
                            s_d.scl_low = 1'b1;
                            s_d.sda_low = (s_q.bitn != ACK_BIT) && !s_q.sh[7];
                        end
                        2'd1: s_d.scl_low = 1'b0;
                        2'd2: if (s_q.bitn == ACK_BIT && sda_i) s_d.fail = 1'b1;
                        default: begin
                            s_d.scl_low = 1'b1;
                            if (s_q.bitn != ACK_BIT) begin
                                s_d.sh   = {s_q.sh[6:0], 1'b0};
                                s_d.bitn = s_q.bitn + 4'd1;
                            end else begin
                                s_d.bitn = 4'd0;
                                if (s_q.fail) begin
                                    s_d.sym = S_STOP;
                                end else begin
                                    case (s_q.step)
                                        P_HDRW: begin
                                            s_d.step = P_ADDR;
                                            s_d.sh   = s_q.addr;
                                        end
                                        P_ADDR: begin
                                            if (s_q.op == OP_WRITE) begin
                                                s_d.step    = P_WDATA;
                                                s_d.sh      = wr_data;
                                                s_d.wr_take = 1'b1;
                                            end else begin
                                                s_d.step = P_HDRR;
                                                s_d.sym  = S_START;
                                            end
                                        end
                                        P_WDATA: begin
                                            if (s_q.left == ONE) begin
                                                s_d.sym = S_STOP;
                                            end else begin
                                                s_d.left    = s_q.left - 1'b1;
                                                s_d.sh      = wr_data;
                                                s_d.wr_take = 1'b1;
                                            end
                                        end
                                        P_HDRR: begin
                                            s_d.step = P_RDATA;
                                            s_d.sym  = S_RX;
                                        end
                                        default: s_d.sym = S_STOP;
                                    endcase
                                end
                            end
                        end
                    endcase
                end
                S_RX: begin
                    case (s_q.q)
                        2'd0: begin
                            s_d.scl_low = 1'b1;
                            s_d.sda_low = (s_q.bitn == ACK_BIT) && (s_q.left != ONE);
                        end
                        2'd1: s_d.scl_low = 1'b0;
                        2'd2: begin
                            if (s_q.bitn != ACK_BIT) begin
                                s_d.sh = {s_q.sh[6:0], sda_i};
                                if (s_q.bitn == 4'd7) begin
                                    s_d.rd_valid = 1'b1;
                                    s_d.rd_data  = {s_q.sh[6:0], sda_i};
                                end
                            end
                        end
                        default: begin
                            s_d.scl_low = 1'b1;
                            if (s_q.bitn != ACK_BIT) begin
                                s_d.bitn = s_q.bitn + 4'd1;
                            end else begin
                                s_d.bitn = 4'd0;
                                if (s_q.left == ONE) begin
                                    s_d.sym = S_STOP;
                                end else begin
                                    s_d.left = s_q.left - 1'b1;
                                end
                            end
                        end
                    endcase
                end
                S_STOP: begin
                    case (s_q.q)
                        2'd0: begin s_d.scl_low = 1'b1; s_d.sda_low = 1'b1; end
                        2'd1: s_d.scl_low = 1'b0;
                        2'd2: s_d.sda_low = 1'b0;
                        default: begin
                            s_d.sym  = S_IDLE;
                            s_d.done = 1'b1;
                            s_d.err  = s_q.fail;
                        end
                    endcase
                end
                default: s_d.sym = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.sym  <= S_IDLE;
            s_q.step <= P_HDRW;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.sym != S_IDLE);
    assign wr_take  = s_q.wr_take;
    assign rd_data  = s_q.rd_data;
    assign rd_valid = s_q.rd_valid;
    assign done     = s_q.done;
    assign err      = s_q.err;
    assign scl_low  = s_q.scl_low;
    assign sda_low  = s_q.sda_low;

    // R1: once idle for two cycles both lines are released
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.sym == S_IDLE && $past(s_q.sym) == S_IDLE) |-> (!s_q.scl_low && !s_q.sda_low));

    // R9: a data-line edge while the clock is released only inside start/stop symbols
    a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.sda_low != $past(s_q.sda_low)) && !$past(s_q.scl_low))
            |-> ($past(s_q.sym) == S_START || $past(s_q.sym) == S_STOP));

    // R10: received-byte strobe is one cycle wide and only follows receive activity
    a_r10_rd_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    a_r10_rd_valid_in_rx: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(s_q.sym) == S_RX));

    // R11: completion is a single-cycle pulse
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: a refused command never leaves idle and reports at once
    a_r8_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_fire && !cmd_ok) |=> (s_q.sym == S_IDLE && err && done));

endmodule

// File: rtl/eeprom_i2c_ctrl.sv
module eeprom_i2c_ctrl
    import eeprom_i2c_pkg::*;
#(
    parameter int QTR_CYC  = 8,
    parameter int LEN_W    = 4,
    parameter int PAGE_MAX = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [1:0]       cmd_op,
    input  logic [2:0]       cmd_dev,
    input  logic [7:0]       cmd_addr,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [7:0]       wr_data,
    output logic             wr_take,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             done,
    output logic             err,
    output logic             scl_oe,
    output logic             sda_oe,
    input  logic             sda_i
);
    logic busy;
    logic tick;
    logic cmd_ok;
    logic cmd_fire;

    assign cmd_ready = !busy;
    assign cmd_fire  = cmd_valid && !busy;

    eeprom_i2c_qtick #(.QTR_CYC(QTR_CYC)) u_qtick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    eeprom_i2c_cmdchk #(.LEN_W(LEN_W), .PAGE_MAX(PAGE_MAX)) u_cmdchk (
        .op  (cmd_op),
        .len (cmd_len),
        .ok  (cmd_ok)
    );

    eeprom_i2c_seq #(.LEN_W(LEN_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cmd_fire (cmd_fire),
        .cmd_ok   (cmd_ok),
        .cmd_op   (cmd_op),
        .cmd_dev  (cmd_dev),
        .cmd_addr (cmd_addr),
        .cmd_len  (cmd_len),
        .wr_data  (wr_data),
        .sda_i    (sda_i),
        .busy     (busy),
        .wr_take  (wr_take),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .done     (done),
        .err      (err),
        .scl_low  (scl_oe),
        .sda_low  (sda_oe)
    );

endmodule

// File: tb/test_eeprom_i2c_ctrl.sv
module test_eeprom_i2c_ctrl;
    localparam int QC   = 2;
    localparam int LW   = 4;
    localparam int PM   = 8;
    localparam logic [2:0] TGT = 3'b101;

    localparam int T_IDLE = 0, T_RX = 1, T_ACKOUT = 2, T_TX = 3, T_ACKIN = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [1:0]    cmd_op = '0;
    logic [2:0]    cmd_dev = '0;
    logic [7:0]    cmd_addr = '0;
    logic [LW-1:0] cmd_len = '0;
    logic [7:0]    wr_data;
    logic          wr_take;
    logic [7:0]    rd_data;
    logic          rd_valid;
    logic          done;
    logic          err;
    logic          scl_oe;
    logic          sda_oe;
    logic          tgt_low;
    logic          scl_line;
    logic          sda_line;

    int vectors = 0;
    int miscmp  = 0;
    int cyc     = 0;

    // target model state
    logic [7:0] mem [256];
    int         tstate;
    int         tbit;
    int         tbyte;
    logic [7:0] tsh;
    logic [7:0] tptr;
    logic       tsel;
    logic       trd;
    logic       cack;
    logic       pscl, psda;
    int         nack_at = -1;

    // per-transaction observations
    int n_start, n_stop, n_rise, n_cack, n_cnack, n_wr, n_rxb, n_take, n_rd;
    int period_bad, pulse_bad;
    int last_rise;
    bit have_last;
    logic [7:0] rd_buf [16];
    logic [7:0] wr_src [16];
    int         wr_idx;
    logic       prev_rdv, prev_done;

    assign scl_line = !scl_oe;
    assign sda_line = !(sda_oe || tgt_low);
    assign wr_data  = wr_src[wr_idx];

    eeprom_i2c_ctrl #(.QTR_CYC(QC), .LEN_W(LW), .PAGE_MAX(PM)) i_eeprom_i2c_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_op    (cmd_op),
        .cmd_dev   (cmd_dev),
        .cmd_addr  (cmd_addr),
        .cmd_len   (cmd_len),
        .wr_data   (wr_data),
        .wr_take   (wr_take),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .done      (done),
        .err       (err),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .sda_i     (sda_line)
    );

    always #5 clk = !clk;

    function automatic logic [7:0] seed(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    // EEPROM-like target on the bus
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] = seed(i);
            tstate = T_IDLE; tbit = 0; tbyte = 0; tsh = '0; tptr = '0;
            tsel = 1'b0; trd = 1'b0; cack = 1'b0;
            tgt_low <= 1'b0;
            pscl = 1'b1; psda = 1'b1;
        end else begin
            if (scl_line && pscl && psda && !sda_line) begin
                n_start++; tstate = T_RX; tbit = 0; tbyte = 0; tgt_low <= 1'b0;
            end else if (scl_line && pscl && !psda && sda_line) begin
                n_stop++; tstate = T_IDLE; tgt_low <= 1'b0; have_last = 1'b0;
            end else if (scl_line && !pscl) begin
                n_rise++;
                if (have_last && (cyc - last_rise) != 4 * QC) period_bad++;
                have_last = 1'b1;
                last_rise = cyc;
                if (tstate == T_RX) begin
                    tsh = {tsh[6:0], sda_line};
                    tbit++;
                end else if (tstate == T_ACKIN) begin
                    cack = !sda_line;
                    if (cack) n_cack++; else n_cnack++;
                end
            end else if (!scl_line && pscl) begin
                case (tstate)
                    T_RX: if (tbit == 8) begin
                        bit ack;
                        n_rxb++;
                        if (tbyte == 0) begin
                            tsel = (tsh[7:1] == {4'b1010, TGT});
                            trd  = tsh[0];
                        end
                        ack = tsel && (tbyte != nack_at);
                        if (ack && !trd && tbyte == 1) tptr = tsh;
                        else if (ack && !trd && tbyte >= 2) begin
                            mem[tptr] = tsh; tptr = tptr + 8'd1; n_wr++;
                        end
                        tbyte++;
                        tbit = 0;
                        tgt_low <= ack;
                        tstate = ack ? T_ACKOUT : T_IDLE;
                    end
                    T_ACKOUT: begin
                        tbit = 0;
                        if (trd) begin
                            tsh = mem[tptr]; tptr = tptr + 8'd1;
                            tgt_low <= !tsh[7];
                            tstate = T_TX;
                        end else begin
                            tgt_low <= 1'b0;
                            tstate = T_RX;
                        end
                    end
                    T_TX: begin
                        tbit++;
                        if (tbit == 8) begin
                            tgt_low <= 1'b0; tstate = T_ACKIN;
                        end else begin
                            tgt_low <= !tsh[3'(7 - tbit)];
                        end
                    end
                    T_ACKIN: begin
                        if (cack) begin
                            tsh = mem[tptr]; tptr = tptr + 8'd1; tbit = 0;
                            tgt_low <= !tsh[7];
                            tstate = T_TX;
                        end else begin
                            tgt_low <= 1'b0; tstate = T_IDLE;
                        end
                    end
                    default: ;
                endcase
            end
            pscl = scl_line;
            psda = sda_line;
        end
    end

    // host-side capture
    always @(posedge clk) begin
        if (rd_valid) begin
            if (n_rd < 16) rd_buf[n_rd] = rd_data;
            n_rd++;
        end
        if (wr_take) begin
            n_take++;
            wr_idx = (wr_idx + 1) & 15;
        end
        if (rd_valid && prev_rdv) pulse_bad++;
        if (done && prev_done) pulse_bad++;
        prev_rdv  = rd_valid;
        prev_done = done;
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscmp++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    endtask

    // issue one command and wait for done; returns err and cmd_ready seen after acceptance
    task automatic run_cmd(input int op, input logic [2:0] dev, input int addr, input int len,
                           output logic e, output logic rdy_after);
        int t;
        n_start = 0; n_stop = 0; n_rise = 0; n_cack = 0; n_cnack = 0;
        n_wr = 0; n_rxb = 0; n_take = 0; n_rd = 0; wr_idx = 0;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_op = 2'(op); cmd_dev = dev; cmd_addr = 8'(addr); cmd_len = LW'(len);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        rdy_after = cmd_ready;
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 20000) begin
            vectors++; miscmp++;
            $display("FAIL R11: actual no done expected done within 20000 cycles");
        end
        e = err;
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        vectors++; miscmp++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : main
        logic e, ra;
        int   ptr;
        period_bad = 0; pulse_bad = 0; have_last = 1'b0; last_rise = 0;
        prev_rdv = 1'b0; prev_done = 1'b0;
        n_take = 0; n_rd = 0; wr_idx = 0;
        for (int i = 0; i < 16; i++) wr_src[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 cmd_ready", int'(cmd_ready), 1);
        chk("R1 scl_oe", int'(scl_oe), 0);
        chk("R1 sda_oe", int'(sda_oe), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 err", int'(err), 0);

        // R3/R2/R10: writes of every legal length
        for (int len = 1; len <= PM; len++) begin
            int a;
            a = (len * 29 + 3) & 255;
            for (int i = 0; i < 16; i++) wr_src[i] = 8'((len * 16 + i * 7 + a) ^ 8'h5A);
            run_cmd(0, TGT, a, len, e, ra);
            chk("R2 header accepted (err)", int'(e), 0);
            chk("R11 cmd_ready low while busy", int'(ra), 0);
            chk("R3 data bytes stored", n_wr, len);
            chk("R3 wr_take pulses", n_take, len);
            for (int i = 0; i < len; i++)
                chk("R10 written byte MSB-first", int'(mem[(a + i) & 255]), int'(wr_src[i]));
            chk("R9 starts in write", n_start, 1);
            chk("R9 stops in write", n_stop, 1);
            chk("R1 lines released after", int'(scl_oe | sda_oe), 0);
        end

        // R4/R6/R5: addressed reads then a read at the current pointer
        for (int len = 1; len <= PM; len++) begin
            int a;
            a = (len * 53 + 100) & 255;
            run_cmd(1, TGT, a, len, e, ra);
            chk("R4 err", int'(e), 0);
            chk("R4 starts incl. repeated", n_start, 2);
            chk("R4 stops", n_stop, 1);
            chk("R10 bytes received", n_rd, len);
            for (int i = 0; i < len; i++)
                chk("R4 read data", int'(rd_buf[i]), int'(mem[(a + i) & 255]));
            chk("R6 controller ACKs", n_cack, len - 1);
            chk("R6 controller NACKs", n_cnack, 1);
            ptr = (a + len) & 255;
            run_cmd(2, TGT, 8'hEE, (len % 3) + 1, e, ra);
            chk("R5 err", int'(e), 0);
            chk("R5 single start", n_start, 1);
            chk("R5 only header sent", n_rxb, 1);
            for (int i = 0; i <= (len % 3); i++)
                chk("R5 data from pointer", int'(rd_buf[i]), int'(mem[(ptr + i) & 255]));
            chk("R6 last byte NACK", n_cnack, 1);
        end

        // R8: refused commands
        for (int len = PM + 1; len < 16; len++) begin
            run_cmd(0, TGT, 0, len, e, ra);
            chk("R8 long page refused", int'(e), 1);
            chk("R8 no bus activity", n_rise + n_start, 0);
        end
        for (int op = 0; op < 3; op++) begin
            run_cmd(op, TGT, 0, 0, e, ra);
            chk("R8 zero length refused", int'(e), 1);
            chk("R8 zero length idle bus", n_rise, 0);
        end
        run_cmd(3, TGT, 0, 2, e, ra);
        chk("R8 reserved op refused", int'(e), 1);
        chk("R8 reserved op idle bus", n_rise, 0);

        // R7: missing acknowledges
        run_cmd(0, 3'b010, 8'h40, 3, e, ra);
        chk("R7 header NACK err", int'(e), 1);
        chk("R7 header NACK stop", n_stop, 1);
        chk("R7 header NACK nothing stored", n_wr, 0);
        chk("R7 header NACK no data fetched", n_take, 0);
        for (int i = 0; i < 16; i++) wr_src[i] = 8'(i + 1);
        nack_at = 3;
        run_cmd(0, TGT, 8'h80, 5, e, ra);
        chk("R7 data NACK err", int'(e), 1);
        chk("R7 data NACK stops sending", n_take, 2);
        chk("R7 data NACK stored before", n_wr, 1);
        chk("R7 data NACK one stop", n_stop, 1);
        nack_at = 1;
        run_cmd(1, TGT, 8'h10, 2, e, ra);
        chk("R7 address NACK err", int'(e), 1);
        chk("R7 address NACK no restart", n_start, 1);
        chk("R7 address NACK no data", n_rd, 0);
        nack_at = -1;
        run_cmd(2, 3'b000, 0, 1, e, ra);
        chk("R7 read header NACK err", int'(e), 1);
        chk("R7 read header NACK no data", n_rd, 0);
        run_cmd(0, TGT, 8'h22, 1, e, ra);
        chk("R7 err cleared by next command", int'(e), 0);

        // R12/R10/R11: timing and pulse widths over the whole run
        chk("R12 SCL rise spacing", period_bad, 0);
        chk("R10 R11 single-cycle pulses", pulse_bad, 0);

        finish_run();
    end

endmodule